// File: doc/BRIEF.md
# SD Host Error Status Logic

This block collects error events from the command and data engines of an SD host controller and records them in a sticky error status word. Each detection input is a single-cycle strobe that only counts when its event-valid signal is high. On the command side it checks the response end bit and compares the returned command index with the expected one. On the data side it checks read data CRC and end bit, the write CRC status token and its end bit, and four timeout expirations. One further bit records an auto-command error. It is set when any bit of the companion auto-command error register goes from 0 to 1, or when an automatic stop command is skipped because an earlier command failed.

Software clears a recorded error by writing a 1 to its status bit. A second register holds one enable bit per status bit. The error interrupt line is high while any recorded error has its enable bit set. The serial framing of CMD and DAT and the CRC generators are outside this block.

Top module: `sd_err_status`

## Requirements
- R1: After reset the status word is 0x0000, the enable register is 0 and `err_irq` is low.
- R2: Status bit 2 is set one cycle after `rsp_valid` is high with `rsp_end_bit` low. A high end bit, or a low end bit without `rsp_valid`, leaves the status unchanged.
- R3: Status bit 3 is set one cycle after `rsp_valid` is high with `rsp_idx` not equal to `exp_idx`.
- R4: Status bit 6 is set one cycle after either of two events: `rd_valid` with `rd_end_bit` low, or `wcrc_valid` with `wcrc_end_bit` low.
- R5: Status bit 5 is set one cycle after either of two events: `rd_valid` with `rd_crc_ok` low, or `wcrc_valid` with a `wcrc_token` other than 3'b010. A token of 3'b010 sets nothing.
- R6: Status bit 4 is set one cycle after any single bit of `to_evt` is high. The bits of `to_evt` are: bit 0, busy timeout after a busy-type response; bit 1, busy timeout after the write CRC status; bit 2, write CRC status timeout; bit 3, read data timeout.
- R7: Status bit 8 is set one cycle after any bit of `acmd_err[4:0]` changes from 0 to 1, or after a pulse on `acmd12_skip`. A bit that stays high does not set bit 8 again once it has been cleared. `acmd_err` is taken to be 0 before the first cycle after reset.
- R8: When `reg_wr_en` is high and `reg_wr_sel` is 0, each status bit whose bit in `reg_wr_data` is 1 is cleared at the next edge. Bits written with 0 keep their value. A set bit otherwise stays set.
- R9: When a hardware set and a write-one-to-clear reach the same bit in the same cycle, the bit is 1 afterwards.
- R10: Status bits 15 to 9, 7, 1 and 0 always read 0, and so does the enable bit for each of these positions.
- R11: When `reg_wr_en` is high and `reg_wr_sel` is 1, `reg_wr_data` is loaded into the enable register. `err_irq` is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rsp_valid | input | 1 | A command response was received this cycle |
| rsp_end_bit | input | 1 | Sampled end bit of the response |
| rsp_idx | input | 6 | Command index carried in the response |
| exp_idx | input | 6 | Command index expected for the response |
| rd_valid | input | 1 | A read data block finished this cycle |
| rd_crc_ok | input | 1 | CRC of the read block matched |
| rd_end_bit | input | 1 | Sampled end bit of the read block |
| wcrc_valid | input | 1 | A write CRC status token was received this cycle |
| wcrc_token | input | 3 | Received CRC status token |
| wcrc_end_bit | input | 1 | End bit of the CRC status token |
| to_evt | input | 4 | Timeout expiration strobes, one per timeout source |
| acmd_err | input | 5 | Low bits of the auto-command error register |
| acmd12_skip | input | 1 | Strobe: automatic stop command skipped after an earlier error |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 = status (write one to clear), 1 = enable |
| reg_wr_data | input | 16 | Register write data |
| status | output | 16 | Sticky error status word |
| err_irq | output | 1 | Error interrupt |

## Verification
Each detector is driven with both a good and a bad value while its valid is high. It is also driven with a bad value while its valid is low. This separates a missing qualification from an inverted check, and the token test uses 010 as well as other patterns. The auto-command input is raised, held across a clear and raised again on a second bit, which tells edge detection from level detection. Other tests hit every source at once, and put a set and a clear on the same bit in the same cycle. A cycle-by-cycle reference model checks the status word and the interrupt line after every clock.

// File: rtl/sd_err_pkg.sv
package sd_err_pkg;

    localparam int STAT_W    = 16;
    localparam int B_CMD_END = 2;
    localparam int B_CMD_IDX = 3;
    localparam int B_DAT_TO  = 4;
    localparam int B_DAT_CRC = 5;
    localparam int B_DAT_END = 6;
    localparam int B_CUR_LIM = 7;
    localparam int B_ACMD    = 8;

    // One flag per implemented error source, raised for one cycle.
    typedef struct packed {
        logic acmd;
        logic dat_end;
        logic dat_crc;
        logic dat_to;
        logic cmd_idx;
        logic cmd_end;
    } err_set_t;

    // Bits that can hold a value; the current-limit bit is never set.
    function automatic logic [STAT_W-1:0] impl_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        m[B_CMD_END] = 1'b1;
        m[B_CMD_IDX] = 1'b1;
        m[B_DAT_TO]  = 1'b1;
        m[B_DAT_CRC] = 1'b1;
        m[B_DAT_END] = 1'b1;
        m[B_ACMD]    = 1'b1;
        return m;
    endfunction

    // Puts the set flags at their positions in the status word.
    function automatic logic [STAT_W-1:0] place(input err_set_t s);
        logic [STAT_W-1:0] v;
        v = '0;
        v[B_CMD_END] = s.cmd_end;
        v[B_CMD_IDX] = s.cmd_idx;
        v[B_DAT_TO]  = s.dat_to;
        v[B_DAT_CRC] = s.dat_crc;
        v[B_DAT_END] = s.dat_end;
        v[B_ACMD]    = s.acmd;
        return v;
    endfunction

endpackage

// File: rtl/sd_cmd_err_chk.sv
module sd_cmd_err_chk #(
    parameter int IDX_W = 6
) (
    input  logic             rsp_valid,
    input  logic             rsp_end_bit,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic [IDX_W-1:0] exp_idx,
    output logic             set_end,
    output logic             set_idx
);

    always_comb begin
        set_end = rsp_valid && !rsp_end_bit;
        set_idx = rsp_valid && (rsp_idx != exp_idx);
    end

endmodule

// File: rtl/sd_dat_err_chk.sv
module sd_dat_err_chk #(
    parameter int                 TOKEN_W  = 3,
    parameter logic [TOKEN_W-1:0] TOKEN_OK = 3'b010,
    parameter int                 TO_N     = 4
) (
    input  logic               rd_valid,
    input  logic               rd_crc_ok,
    input  logic               rd_end_bit,
    input  logic               wcrc_valid,
    input  logic [TOKEN_W-1:0] wcrc_token,
    input  logic               wcrc_end_bit,
    input  logic [TO_N-1:0]    to_evt,
    output logic               set_end,
    output logic               set_crc,
    output logic               set_to
);

    logic [TO_N:0] to_chain;

    // OR of the timeout sources, built as a chain so TO_N may change freely.
    assign to_chain[0] = 1'b0;
    for (genvar i = 0; i < TO_N; i++) begin : g_to
        assign to_chain[i+1] = to_chain[i] | to_evt[i];
    end

    always_comb begin
        set_end = (rd_valid && !rd_end_bit) || (wcrc_valid && !wcrc_end_bit);
        set_crc = (rd_valid && !rd_crc_ok) || (wcrc_valid && (wcrc_token != TOKEN_OK));
        set_to  = to_chain[TO_N];
    end

endmodule

// File: rtl/sd_acmd_edge.sv
module sd_acmd_edge #(
    parameter int ACMD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACMD_W-1:0] acmd_err,
    input  logic              acmd12_skip,
    output logic              set_acmd
);

    typedef struct packed {
        logic [ACMD_W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [ACMD_W-1:0] rise;

    always_comb begin
        st_d.prev = acmd_err;
        rise      = acmd_err & ~st_q.prev;
        set_acmd  = (|rise) || acmd12_skip;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sd_err_status.sv
module sd_err_status
    import sd_err_pkg::*;
#(
    parameter int                 IDX_W    = 6,
    parameter int                 ACMD_W   = 5,
    parameter int                 TOKEN_W  = 3,
    parameter logic [TOKEN_W-1:0] TOKEN_OK = 3'b010,
    parameter int                 TO_N     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsp_valid,
    input  logic               rsp_end_bit,
    input  logic [IDX_W-1:0]   rsp_idx,
    input  logic [IDX_W-1:0]   exp_idx,
    input  logic               rd_valid,
    input  logic               rd_crc_ok,
    input  logic               rd_end_bit,
    input  logic               wcrc_valid,
    input  logic [TOKEN_W-1:0] wcrc_token,
    input  logic               wcrc_end_bit,
    input  logic [TO_N-1:0]    to_evt,
    input  logic [ACMD_W-1:0]  acmd_err,
    input  logic               acmd12_skip,
    input  logic               reg_wr_en,
    input  logic               reg_wr_sel,
    input  logic [STAT_W-1:0]  reg_wr_data,
    output logic [STAT_W-1:0]  status,
    output logic               err_irq
);

    localparam logic [STAT_W-1:0] IMPL = impl_mask();

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] en;
    } reg_st_t;

    reg_st_t  st_d, st_q;
    err_set_t set_ev;
    logic [STAT_W-1:0] set_vec, clr_vec;

    sd_cmd_err_chk #(.IDX_W(IDX_W)) u_cmd (
        .rsp_valid   (rsp_valid),
        .rsp_end_bit (rsp_end_bit),
        .rsp_idx     (rsp_idx),
        .exp_idx     (exp_idx),
        .set_end     (set_ev.cmd_end),
        .set_idx     (set_ev.cmd_idx)
    );

    sd_dat_err_chk #(
        .TOKEN_W  (TOKEN_W),
        .TOKEN_OK (TOKEN_OK),
        .TO_N     (TO_N)
    ) u_dat (
        .rd_valid     (rd_valid),
        .rd_crc_ok    (rd_crc_ok),
        .rd_end_bit   (rd_end_bit),
        .wcrc_valid   (wcrc_valid),
        .wcrc_token   (wcrc_token),
        .wcrc_end_bit (wcrc_end_bit),
        .to_evt       (to_evt),
        .set_end      (set_ev.dat_end),
        .set_crc      (set_ev.dat_crc),
        .set_to       (set_ev.dat_to)
    );

    sd_acmd_edge #(.ACMD_W(ACMD_W)) u_acmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .acmd_err    (acmd_err),
        .acmd12_skip (acmd12_skip),
        .set_acmd    (set_ev.acmd)
    );

    always_comb begin
        set_vec = place(set_ev);
        clr_vec = (reg_wr_en && !reg_wr_sel) ? reg_wr_data : '0;
        st_d    = st_q;
        // A hardware set has priority over a clear in the same cycle.
        st_d.stat = ((st_q.stat & ~clr_vec) | set_vec) & IMPL;
        if (reg_wr_en && reg_wr_sel) begin
            st_d.en = reg_wr_data & IMPL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status  = st_q.stat;
    assign err_irq = |(st_q.stat & st_q.en);

endmodule

// File: rtl/sd_err_status_chk.sv
module sd_err_status_chk #(
    parameter int IDX_W   = 6,
    parameter int TOKEN_W = 3,
    parameter int TO_N    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rsp_valid,
    input logic               rsp_end_bit,
    input logic [IDX_W-1:0]   rsp_idx,
    input logic [IDX_W-1:0]   exp_idx,
    input logic               wcrc_valid,
    input logic [TOKEN_W-1:0] wcrc_token,
    input logic [TO_N-1:0]    to_evt,
    input logic               acmd12_skip,
    input logic               reg_wr_en,
    input logic               reg_wr_sel,
    input logic [15:0]        reg_wr_data,
    input logic [15:0]        status,
    input logic               err_irq
);

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 16'hFE83) == 16'h0000);

    p_cmd_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_end_bit) |=> status[2]);

    p_cmd_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_idx != exp_idx)) |=> status[3]);

    p_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wcrc_valid && (wcrc_token != 3'b010)) |=> status[5]);

    p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|to_evt) |=> status[4]);

    p_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acmd12_skip |=> status[8]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !(reg_wr_en && !reg_wr_sel && reg_wr_data[2])) |=> status[2]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel && reg_wr_data[2] && rsp_valid && !rsp_end_bit) |=> status[2]);

    p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (|status));

endmodule

bind sd_err_status sd_err_status_chk #(
    .IDX_W   (IDX_W),
    .TOKEN_W (TOKEN_W),
    .TO_N    (TO_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (rsp_valid),
    .rsp_end_bit (rsp_end_bit),
    .rsp_idx     (rsp_idx),
    .exp_idx     (exp_idx),
    .wcrc_valid  (wcrc_valid),
    .wcrc_token  (wcrc_token),
    .to_evt      (to_evt),
    .acmd12_skip (acmd12_skip),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .status      (status),
    .err_irq     (err_irq)
);

// File: tb/sim_sd_err_status.sv
`timescale 1ns/1ps
module sim_sd_err_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 0, rsp_end_bit = 1;
    logic [5:0]  rsp_idx = 0, exp_idx = 0;
    logic        rd_valid = 0, rd_crc_ok = 1, rd_end_bit = 1;
    logic        wcrc_valid = 0, wcrc_end_bit = 1;
    logic [2:0]  wcrc_token = 3'b010;
    logic [3:0]  to_evt = 0;
    logic [4:0]  acmd_err = 0;
    logic        acmd12_skip = 0;
    logic        reg_wr_en = 0, reg_wr_sel = 0;
    logic [15:0] reg_wr_data = 0;
    logic [15:0] status;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_st = 0, m_en = 0;
    logic [4:0]  m_prev = 0;

    always #10 clk = ~clk;

    sd_err_status u0 (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_end_bit(rsp_end_bit),
        .rsp_idx(rsp_idx), .exp_idx(exp_idx),
        .rd_valid(rd_valid), .rd_crc_ok(rd_crc_ok), .rd_end_bit(rd_end_bit),
        .wcrc_valid(wcrc_valid), .wcrc_token(wcrc_token), .wcrc_end_bit(wcrc_end_bit),
        .to_evt(to_evt), .acmd_err(acmd_err), .acmd12_skip(acmd12_skip),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .status(status), .err_irq(err_irq)
    );

    always @(posedge clk) begin
        logic [15:0] s, c;
        if (!rst_n) begin
            m_st <= 0; m_en <= 0; m_prev <= 0;
        end else begin
            s = 0;
            if (rsp_valid && rsp_end_bit == 0) s[2] = 1;
            if (rsp_valid && rsp_idx != exp_idx) s[3] = 1;
            if (to_evt != 0) s[4] = 1;
            if ((rd_valid && !rd_crc_ok) || (wcrc_valid && wcrc_token != 3'b010)) s[5] = 1;
            if ((rd_valid && !rd_end_bit) || (wcrc_valid && !wcrc_end_bit)) s[6] = 1;
            for (int i = 0; i < 5; i++)
                if (acmd_err[i] && !m_prev[i]) s[8] = 1;
            if (acmd12_skip) s[8] = 1;
            c = (reg_wr_en && !reg_wr_sel) ? reg_wr_data : 16'h0;
            m_st <= ((m_st & ~c) | s) & 16'h017C;
            if (reg_wr_en && reg_wr_sel) m_en <= reg_wr_data & 16'h017C;
            m_prev <= acmd_err;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (status !== m_st || err_irq !== |(m_st & m_en)) begin
                errors++;
                $display("FAIL R8 model compare: status=%h irq=%b expected status=%h irq=%b",
                         status, err_irq, m_st, |(m_st & m_en));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rsp_valid = 0; rsp_end_bit = 1; rsp_idx = 0; exp_idx = 0;
        rd_valid = 0; rd_crc_ok = 1; rd_end_bit = 1;
        wcrc_valid = 0; wcrc_token = 3'b010; wcrc_end_bit = 1;
        to_evt = 0; acmd12_skip = 0;
        reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 0;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
        tick(); idle();
    endtask

    task automatic clear_all();
        wr(0, 16'hFFFF);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 status after reset", status, 16'h0000);
        chk("R1 irq after reset", {15'h0, err_irq}, 16'h0000);

        rsp_valid = 1; rsp_end_bit = 1; rsp_idx = 6'd17; exp_idx = 6'd17;
        tick(); idle(); tick();
        chk("R2 good response no effect", status, 16'h0000);
        rsp_valid = 0; rsp_end_bit = 0;
        tick(); idle(); tick();
        chk("R2 end bit without valid ignored", status, 16'h0000);
        rsp_valid = 1; rsp_end_bit = 0; rsp_idx = 6'd5; exp_idx = 6'd5;
        tick(); idle();
        chk("R2 end bit error", status, 16'h0004);
        rsp_valid = 1; rsp_idx = 6'd12; exp_idx = 6'd13;
        tick(); idle();
        chk("R3 index mismatch", status, 16'h000C);

        wr(0, 16'h0008);
        chk("R8 clear one bit", status, 16'h0004);
        wr(0, 16'h0000);
        chk("R8 write zero keeps", status, 16'h0004);
        clear_all();
        chk("R8 clear all", status, 16'h0000);

        rd_valid = 1; rd_crc_ok = 0;
        tick(); idle();
        chk("R5 read crc error", status, 16'h0020);
        clear_all();
        wcrc_valid = 1; wcrc_token = 3'b010;
        tick(); idle(); tick();
        chk("R5 token 010 accepted", status, 16'h0000);
        wcrc_valid = 1; wcrc_token = 3'b101;
        tick(); idle();
        chk("R5 token 101 rejected", status, 16'h0020);
        clear_all();
        wcrc_valid = 1; wcrc_token = 3'b011;
        tick(); idle();
        chk("R5 token 011 rejected", status, 16'h0020);
        clear_all();
        wcrc_valid = 1; wcrc_end_bit = 0;
        tick(); idle();
        chk("R4 token end bit", status, 16'h0040);
        clear_all();
        rd_valid = 1; rd_end_bit = 0;
        tick(); idle();
        chk("R4 read end bit", status, 16'h0040);
        clear_all();

        for (int k = 0; k < 4; k++) begin
            to_evt = 4'b0001 << k;
            tick(); idle();
            chk("R6 timeout source", status, 16'h0010);
            clear_all();
        end

        acmd_err = 5'b00100;
        tick();
        chk("R7 rising edge", status, 16'h0100);
        clear_all();
        tick();
        chk("R7 held level no re-set", status, 16'h0000);
        acmd_err = 5'b00101;
        tick();
        chk("R7 second bit rises", status, 16'h0100);
        clear_all();
        acmd_err = 5'b00000;
        tick(); tick();
        chk("R7 falling edge ignored", status, 16'h0000);
        acmd12_skip = 1;
        tick(); idle();
        chk("R7 skipped stop command", status, 16'h0100);
        clear_all();

        rsp_valid = 1; rsp_end_bit = 0;
        tick(); idle();
        rsp_valid = 1; rsp_end_bit = 0;
        reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = 16'h0004;
        tick(); idle();
        chk("R9 set beats clear", status, 16'h0004);
        clear_all();

        rsp_valid = 1; rsp_end_bit = 0; rsp_idx = 1; exp_idx = 2;
        rd_valid = 1; rd_crc_ok = 0; rd_end_bit = 0;
        to_evt = 4'hF; acmd12_skip = 1;
        tick(); idle();
        chk("R10 all sources", status, 16'h017C);
        chk("R10 unused bits zero", status & 16'hFE83, 16'h0000);
        chk("R11 no enable no irq", {15'h0, err_irq}, 16'h0000);
        wr(1, 16'h0004);
        chk("R11 enabled bit raises irq", {15'h0, err_irq}, 16'h0001);
        wr(0, 16'h0004);
        chk("R11 irq drops when bit cleared", {15'h0, err_irq}, 16'h0000);
        wr(1, 16'hFE83);
        chk("R10 unused enable bits ignored", {15'h0, err_irq}, 16'h0000);
        wr(1, 16'h0100);
        chk("R11 other enabled bit", {15'h0, err_irq}, 16'h0001);
        clear_all();
        chk("R11 irq low after clear", {15'h0, err_irq}, 16'h0000);

        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule